// File: doc/BRIEF.md
# Hall Commutation Decoder with Direction Control

This block turns three digitized Hall sensor levels into switch enables for a three-phase bipolar bridge. Each valid sensor state selects one phase whose high-side switch sources current and a different phase whose low-side switch sinks it. The third phase floats. A direction input reverses rotation by decoding the bitwise inverse of the sensor code through the same six-step table.

The sensor levels are first brought into the clock domain by a synchronizer. An agreement filter then rejects short noise pulses. Whenever the requested switch pair changes, whether from a sensor edge or a direction flip, all six enables are held off for a programmable dead time before the new pair is driven. Duty-cycle chopping, the peak current limit and the protection latch act only on the low-side switches, so the high side stays fully on for its whole step. A stop input turns off all six switches.

Top module: `hall_commutator`

## Requirements
- R1: In forward mode (`dir_rev`=0), with the code formed as {phase3,phase2,phase1} sensor bits, the decoder drives exactly one high-side and one different low-side enable. The mapping is code 1→high phase3/low phase1, 3→high3/low2, 2→high1/low2, 6→high1/low3, 4→high2/low3, 5→high2/low1. Bit i of `hi_en`/`lo_en` drives phase i+1.
- R2: In reverse mode (`dir_rev`=1), the decoder uses the forward mapping of the bitwise-inverted code. For example, reverse code 2 gives high phase2/low phase1.
- R3: The codes 000 and 111 decode to all six enables off in both directions.
- R4: The sensor inputs pass through a 2-flop synchronizer. A new level is accepted only after 3 consecutive agreeing synchronized samples, so a level lasting 2 cycles or less is ignored.
- R5: When the requested pair changes, all six enables go off for exactly `dead_cycles`+1 cycles before the new pair appears. A sensor change reaches the outputs `dead_cycles`+8 clock edges after it is applied. A direction change alone reaches the outputs `dead_cycles`+2 edges after it is applied. The outputs never switch directly from one non-off pair to another.
- R6: With `pwm_on` low, the low-side enables are off while the high-side enable is unchanged.
- R7: `ilim_trip` turns the low side off in the same cycle. The low side stays off until a cycle in which `pwm_period_start` is high and `ilim_trip` is low has passed. A trip that coincides with a period start keeps the low side off. The high side is unaffected.
- R8: With `run_en` low, all six enables are off.
- R9: With `prot_latched` high, the low-side enables are off and the high side is unchanged.
- R10: During and after reset, all six enables are off until a valid sensor code has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_raw | input | 3 | Digitized sensor levels, bit i = phase i+1 |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| run_en | input | 1 | 1 run, 0 stop (all switches off) |
| pwm_on | input | 1 | PWM carrier on-phase for the low side |
| pwm_period_start | input | 1 | One-cycle pulse at each PWM period start |
| ilim_trip | input | 1 | Peak current limit comparator |
| prot_latched | input | 1 | Protection latch active |
| dead_cycles | input | 8 | Dead-time length in clock cycles |
| hi_en | output | 3 | High-side switch enables |
| lo_en | output | 3 | Low-side switch enables |

## Verification
On every cycle, the embedded assertions check the following: the high and low enables never overlap and each has at most one bit set; the decoder output is a legal pair for valid codes and empty for invalid ones; the filter only takes values that its sample window held; the dead-time stage never swaps between two driven pairs; and the low side stays off in the cycle after an unresolved current-limit trip. Only the bench scenarios can show the exact step table in both directions, the precise latency and dead-window length for several `dead_cycles` values, rejection of a short sensor pulse, and the release of the current-limit hold at a period start.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

  typedef struct packed {
    logic [2:0] hi;
    logic [2:0] lo;
  } drive_pair_t;

  localparam drive_pair_t PAIR_OFF = '0;

  // Forward six-step table; code = {phase3, phase2, phase1}
  function automatic drive_pair_t fwd_step(input logic [2:0] code);
    drive_pair_t p;
    p = PAIR_OFF;
    case (code)
      3'd1: begin p.hi = 3'b100; p.lo = 3'b001; end
      3'd3: begin p.hi = 3'b100; p.lo = 3'b010; end
      3'd2: begin p.hi = 3'b001; p.lo = 3'b010; end
      3'd6: begin p.hi = 3'b001; p.lo = 3'b100; end
      3'd4: begin p.hi = 3'b010; p.lo = 3'b100; end
      3'd5: begin p.hi = 3'b010; p.lo = 3'b001; end
      default: p = PAIR_OFF;
    endcase
    return p;
  endfunction

  // Reverse reuses the forward table on the inverted code
  function automatic drive_pair_t decode_step(input logic [2:0] code, input logic rev);
    return fwd_step(rev ? ~code : code);
  endfunction

  function automatic logic code_valid(input logic [2:0] code);
    return (code != 3'b000) && (code != 3'b111);
  endfunction

endpackage

// File: rtl/hall_sync_filter.sv
module hall_sync_filter #(
  parameter int W     = 3,
  parameter int SYNC  = 2,
  parameter int AGREE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt,
  output logic         agree
);

  logic [SYNC-1:0][W-1:0]  sync_q;
  logic [AGREE-1:0][W-1:0] win_q;
  logic [AGREE-1:0]        match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      win_q  <= '0;
      filt   <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
      win_q[0] <= sync_q[SYNC-1];
      for (int i = 1; i < AGREE; i++) win_q[i] <= win_q[i-1];
      if (agree) filt <= win_q[0];
    end
  end

  assign match[0] = 1'b1;
  for (genvar g = 1; g < AGREE; g++) begin : g_match
    assign match[g] = (win_q[g] == win_q[0]);
  end
  assign agree = &match;

  AST_FILT_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> (filt == $past(win_q[AGREE-1]))); // R4

endmodule

// File: rtl/step_decoder.sv
module step_decoder
  import hcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  code,
  input  logic        rev,
  output drive_pair_t req
);

  logic valid;

  assign valid = code_valid(code);
  assign req   = decode_step(code, rev);

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($onehot(req.hi) && $onehot(req.lo) && ((req.hi & req.lo) == 3'b000))); // R1
  AST_STEP_INVALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (req == PAIR_OFF)); // R3

endmodule

// File: rtl/dead_time_seq.sv
module dead_time_seq
  import hcd_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  drive_pair_t     req,
  input  logic [DT_W-1:0] dead_cycles,
  output drive_pair_t     act,
  output logic            pair_change
);

  drive_pair_t     pend_q;
  logic [DT_W-1:0] cnt_q;

  assign pair_change = (req != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PAIR_OFF;
      act    <= PAIR_OFF;
      cnt_q  <= '0;
    end else if (pair_change) begin
      pend_q <= req;
      cnt_q  <= dead_cycles;
      act    <= PAIR_OFF;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      act    <= pend_q;
    end
  end

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(act) != PAIR_OFF) && (act != PAIR_OFF)) |-> (act == $past(act))); // R5

endmodule

// File: rtl/low_side_gate.sv
module low_side_gate #(
  parameter int PH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PH-1:0] lo_sel,
  input  logic          run_en,
  input  logic          pwm_on,
  input  logic          period_start,
  input  logic          ilim_trip,
  input  logic          prot_latched,
  output logic [PH-1:0] lo_en,
  output logic          ilim_block
);

  logic hold_q;
  logic allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold_q <= 1'b0;
    else if (ilim_trip)    hold_q <= 1'b1;
    else if (period_start) hold_q <= 1'b0;
  end

  assign ilim_block = ilim_trip | hold_q;
  assign allow      = run_en & pwm_on & ~prot_latched & ~ilim_block;

  for (genvar g = 0; g < PH; g++) begin : g_phase
    assign lo_en[g] = lo_sel[g] & allow;
  end

  AST_LIMIT_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ilim_trip) && !$past(period_start)) |-> (lo_en == '0)); // R7

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hcd_pkg::*;
#(
  parameter int DT_W  = 8,
  parameter int SYNC  = 2,
  parameter int AGREE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      hall_raw,
  input  logic            dir_rev,
  input  logic            run_en,
  input  logic            pwm_on,
  input  logic            pwm_period_start,
  input  logic            ilim_trip,
  input  logic            prot_latched,
  input  logic [DT_W-1:0] dead_cycles,
  output logic [2:0]      hi_en,
  output logic [2:0]      lo_en
);

  logic [2:0]  hall_filt;
  logic        hall_agree;
  drive_pair_t req_pair;
  drive_pair_t act_pair;
  logic        pair_change;
  logic        ilim_block;

  hall_sync_filter #(.W(3), .SYNC(SYNC), .AGREE(AGREE)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (hall_raw),
    .filt  (hall_filt),
    .agree (hall_agree)
  );

  step_decoder u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (hall_filt),
    .rev   (dir_rev),
    .req   (req_pair)
  );

  dead_time_seq #(.DT_W(DT_W)) u_dead (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req_pair),
    .dead_cycles (dead_cycles),
    .act         (act_pair),
    .pair_change (pair_change)
  );

  low_side_gate #(.PH(3)) u_low (
    .clk          (clk),
    .rst_n        (rst_n),
    .lo_sel       (act_pair.lo),
    .run_en       (run_en),
    .pwm_on       (pwm_on),
    .period_start (pwm_period_start),
    .ilim_trip    (ilim_trip),
    .prot_latched (prot_latched),
    .lo_en        (lo_en),
    .ilim_block   (ilim_block)
  );

  assign hi_en = act_pair.hi & {3{run_en}};

  AST_PAIR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (((hi_en & lo_en) == 3'b000) && $onehot0(hi_en) && $onehot0(lo_en))); // R1

  AST_NO_DRIVE_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pair_change) |-> ((hi_en == 3'b000) && (lo_en == 3'b000))); // R5

endmodule

// File: tb/sim_hall_commutator.sv
module sim_hall_commutator;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hall_raw;
  logic       dir_rev, run_en, pwm_on, pwm_period_start, ilim_trip, prot_latched;
  logic [7:0] dead_cycles;
  logic [2:0] hi_en, lo_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hall_commutator u0 (
    .clk(clk), .rst_n(rst_n), .hall_raw(hall_raw), .dir_rev(dir_rev),
    .run_en(run_en), .pwm_on(pwm_on), .pwm_period_start(pwm_period_start),
    .ilim_trip(ilim_trip), .prot_latched(prot_latched),
    .dead_cycles(dead_cycles), .hi_en(hi_en), .lo_en(lo_en)
  );

  // {dir, code, expected hi, expected lo}
  localparam logic [9:0] VEC [14] = '{
    {1'b0, 3'd1, 3'b100, 3'b001}, {1'b0, 3'd3, 3'b100, 3'b010},
    {1'b0, 3'd2, 3'b001, 3'b010}, {1'b0, 3'd6, 3'b001, 3'b100},
    {1'b0, 3'd4, 3'b010, 3'b100}, {1'b0, 3'd5, 3'b010, 3'b001},
    {1'b0, 3'd7, 3'b000, 3'b000},
    {1'b1, 3'd6, 3'b100, 3'b001}, {1'b1, 3'd2, 3'b010, 3'b001},
    {1'b1, 3'd4, 3'b100, 3'b010}, {1'b1, 3'd5, 3'b001, 3'b010},
    {1'b1, 3'd1, 3'b001, 3'b100}, {1'b1, 3'd3, 3'b010, 3'b100},
    {1'b1, 3'd0, 3'b000, 3'b000}
  };

  // Sensor-to-output latency: sync 2 + window 3 + filter 1 + pending 1 + apply 1 + dead
  function automatic int hall_lat(input int d);
    return 8 + d;
  endfunction

  task automatic check(input string req, input logic [2:0] eh, input logic [2:0] el);
    checks++;
    if (hi_en !== eh || lo_en !== el) begin
      errors++;
      $display("FAIL %s: hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b", req, hi_en, lo_en, eh, el);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hall_raw = 3'd0; dir_rev = 1'b0; run_en = 1'b1; pwm_on = 1'b1;
    pwm_period_start = 1'b0; ilim_trip = 1'b0; prot_latched = 1'b0; dead_cycles = 8'd2;
    wait_n(3);
    check("R10 in reset", 3'b000, 3'b000);
    rst_n = 1'b1;
    wait_n(12);
    check("R10 after reset", 3'b000, 3'b000);

    // Table walk: dead window one sample before the new pair, then the pair
    for (int i = 0; i < 14; i++) begin
      dir_rev  = VEC[i][9];
      hall_raw = VEC[i][8:6];
      wait_n(hall_lat(2) - 1);
      check("R5 dead window", 3'b000, 3'b000);
      wait_n(1);
      if (VEC[i][5:0] == 6'd0)  check("R3 invalid code", 3'b000, 3'b000);
      else if (VEC[i][9])       check("R2 reverse step", VEC[i][5:3], VEC[i][2:0]);
      else                      check("R1 forward step", VEC[i][5:3], VEC[i][2:0]);
    end

    dir_rev = 1'b0; hall_raw = 3'd1;
    wait_n(hall_lat(2) + 2);
    check("R1 setup", 3'b100, 3'b001);

    // R6 chopping on low side only
    pwm_on = 1'b0; #1;
    check("R6 pwm off", 3'b100, 3'b000);
    wait_n(1); pwm_on = 1'b1; #1;
    check("R6 pwm on", 3'b100, 3'b001);

    // R7 current limit hold
    wait_n(1); ilim_trip = 1'b1; #1;
    check("R7 trip immediate", 3'b100, 3'b000);
    wait_n(1); ilim_trip = 1'b0; #1;
    check("R7 hold after trip", 3'b100, 3'b000);
    wait_n(3);
    check("R7 hold until period", 3'b100, 3'b000);
    pwm_period_start = 1'b1; ilim_trip = 1'b1;
    wait_n(1); pwm_period_start = 1'b0; ilim_trip = 1'b0; #1;
    check("R7 trip wins over period start", 3'b100, 3'b000);
    pwm_period_start = 1'b1;
    wait_n(1); pwm_period_start = 1'b0; #1;
    check("R7 released at period start", 3'b100, 3'b001);

    // R9 protection
    prot_latched = 1'b1; #1;
    check("R9 protection", 3'b100, 3'b000);
    wait_n(2);
    check("R9 protection held", 3'b100, 3'b000);
    prot_latched = 1'b0; #1;
    check("R9 protection cleared", 3'b100, 3'b001);

    // R8 stop
    run_en = 1'b0; #1;
    check("R8 stop", 3'b000, 3'b000);
    wait_n(1); run_en = 1'b1; #1;
    check("R8 run again", 3'b100, 3'b001);

    // R4 short pulse rejected
    begin
      int bad = 0;
      hall_raw = 3'd3;
      wait_n(2);
      hall_raw = 3'd1;
      for (int k = 0; k < 14; k++) begin
        wait_n(1);
        if (hi_en !== 3'b100 || lo_en !== 3'b001) bad++;
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R4 glitch: %0d disturbed samples, expected 0", bad);
      end
    end

    // R5 zero dead time
    dead_cycles = 8'd0; hall_raw = 3'd3;
    wait_n(hall_lat(0) - 1);
    check("R5 dead 0 gap", 3'b000, 3'b000);
    wait_n(1);
    check("R5 dead 0 pair", 3'b100, 3'b010);

    // R5 longer dead time: count the off window
    begin
      int offs = 0;
      int olds = 0;
      dead_cycles = 8'd5; hall_raw = 3'd2;
      for (int k = 0; k < hall_lat(5) - 1; k++) begin
        wait_n(1);
        if (hi_en === 3'b000 && lo_en === 3'b000) offs++;
        else if (hi_en === 3'b100 && lo_en === 3'b010) olds++;
      end
      checks++;
      if (offs != 6 || olds != 6) begin
        errors++;
        $display("FAIL R5 dead 5 window: off=%0d old=%0d expected off=6 old=6", offs, olds);
      end
      wait_n(1);
      check("R5 dead 5 pair", 3'b001, 3'b010);
    end

    // R2/R5 direction-only flip: new pair after dead+2 edges
    dead_cycles = 8'd2; dir_rev = 1'b1;
    wait_n(3);
    check("R5 dir flip gap", 3'b000, 3'b000);
    wait_n(1);
    check("R2 dir flip pair", 3'b010, 3'b001);

    // R10 reset mid-run
    rst_n = 1'b0; #1;
    check("R10 reset mid-run", 3'b000, 3'b000);
    wait_n(2); rst_n = 1'b1;
    wait_n(2);
    check("R10 after mid-run reset", 3'b000, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule